// File: doc/BRIEF.md
# Survivor-Aware Add-Compare-Select Cell

This block is one radix-2 add-compare-select cell for a state-parallel adaptive Viterbi decoder whose purge limit is fixed at zero. Each clock it takes two incoming branches. Each branch brings a normalized branch metric, the path metric of its predecessor state and the validity bit of that predecessor. Only branches whose predecessor is a live survivor compete. The cell registers four results: a winner path metric, a validity bit, a decision bit and a threshold-pass flag.

A winner is kept as a survivor only when its metric is negative, so the sign bit stands in for a comparison against the fixed zero limit. When no survivor results, the winner metric register holds its old value, which saves toggling in the cells that read it. The threshold flag marks survivors whose metric lies below a level near the bottom of the retention window. An external AND across all cells uses these flags to choose the normalization bias. One instance is placed per trellis state, and the cells are wired through the trellis connections.

Top module: `surv_acs_cell`

## Requirements
- R1: When both branches are valid, the smaller saturated sum (path metric plus branch metric) wins. dec_out is 1 when the lower branch (index 1) wins and 0 when the upper branch (index 0) wins.
- R2: When exactly one branch is valid, its sum is taken whatever the comparison would give. dec_out then equals the index of the valid branch: 0 for upper, 1 for lower.
- R3: When neither branch is valid, vld_out and dec_out are 0 after the next edge.
- R4: vld_out is 1 only when at least one branch was valid and the chosen sum is negative. The test uses the sign bit, bit W-1.
- R5: When the new validity is 0, pm_out keeps its previous value.
- R6: thr_out is 1 exactly when the new winner is a survivor and its metric is strictly below the level DELTA-WIN (default -14).
- R7: In reset, a cell with IS_START=1 holds pm_out=-WIN (default -16) and vld_out=1. Any other cell holds pm_out=0 and vld_out=0. Every cell holds dec_out=0 and thr_out=0.
- R8: Sums are W-bit two's complement (default 6 bits) and saturate to the range -32..31. They never wrap.
- R9: On a tie between two valid branches, the upper branch wins and dec_out is 0.
- R10: load_init high at an edge loads the reset values of R7 synchronously, overriding the branch inputs.
- R11: All four outputs are registered. They reflect the inputs present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_init | input | 1 | Synchronous load of start-up values |
| bm_up | input | W | Normalized branch metric, upper branch (signed) |
| bm_lo | input | W | Normalized branch metric, lower branch (signed) |
| pm_up | input | W | Predecessor path metric, upper branch (signed) |
| pm_lo | input | W | Predecessor path metric, lower branch (signed) |
| vld_up | input | 1 | Predecessor of upper branch is a survivor |
| vld_lo | input | 1 | Predecessor of lower branch is a survivor |
| pm_out | output | W | Registered winner path metric (signed) |
| vld_out | output | 1 | Registered survivor flag |
| dec_out | output | 1 | Registered decision bit |
| thr_out | output | 1 | Registered threshold-pass flag |

## Verification
Saturation and threshold detection can act on the same sum in the same cycle. A low-end overflow must clamp to -32 and still raise both vld_out and thr_out. A high-end overflow must clamp to +31, which makes the path a nonsurvivor, so the metric register holds its old value. The bench provokes both cases with operands whose unclamped sum would wrap to the opposite sign. It then judges vld_out, thr_out and the held pm_out on the following cycle. A four-state trellis of cells is also stepped against a bench model, so that loss and recovery of survivors across states are checked together.

// File: rtl/acs_pkg.sv
package acs_pkg;
  // which candidates take part in the selection
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_UP   = 2'd1,
    PICK_LO   = 2'd2,
    PICK_CMP  = 2'd3
  } pick_e;
endpackage

// File: rtl/acs_sat_add.sv
module acs_sat_add #(
  parameter int W = 6
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] s
);
  localparam logic signed [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide;

  always_comb begin
    wide = {a[W-1], a} + {b[W-1], b};
    if (wide[W] != wide[W-1]) begin
      s = wide[W] ? S_MIN : S_MAX;   // R8: clamp instead of wrap
    end else begin
      s = wide[W-1:0];
    end
  end
endmodule

// File: rtl/acs_pick.sv
module acs_pick
  import acs_pkg::*;
#(
  parameter int W = 6
) (
  input  logic signed [W-1:0] sum_up,
  input  logic signed [W-1:0] sum_lo,
  input  logic                v_up,
  input  logic                v_lo,
  output logic signed [W-1:0] win,
  output logic                dec,
  output logic                vld
);
  pick_e mode;

  always_comb begin
    unique case ({v_lo, v_up})
      2'b11:   mode = PICK_CMP;
      2'b01:   mode = PICK_UP;
      2'b10:   mode = PICK_LO;
      default: mode = PICK_NONE;
    endcase

    win = sum_up;
    dec = 1'b0;
    unique case (mode)
      PICK_CMP: begin
        if (sum_lo < sum_up) begin      // R1, tie keeps upper (R9)
          win = sum_lo;
          dec = 1'b1;
        end
      end
      PICK_LO: begin                    // R2
        win = sum_lo;
        dec = 1'b1;
      end
      default: begin                    // PICK_UP and PICK_NONE (R3)
        win = sum_up;
        dec = 1'b0;
      end
    endcase

    vld = (mode != PICK_NONE) && win[W-1];   // R4: zero purge limit
  end
endmodule

// File: rtl/acs_state_reg.sv
module acs_state_reg #(
  parameter int W        = 6,
  parameter int WIN      = 16,
  parameter int DELTA    = 2,
  parameter bit IS_START = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_init,
  input  logic signed [W-1:0] win,
  input  logic                vld_d,
  input  logic                dec_d,
  output logic signed [W-1:0] pm_q,
  output logic                vld_q,
  output logic                dec_q,
  output logic                thr_q
);
  localparam int                  INIT_I  = IS_START ? -WIN : 0;
  localparam int                  THR_I   = DELTA - WIN;
  localparam logic signed [W-1:0] INIT_PM = INIT_I[W-1:0];
  localparam logic signed [W-1:0] THR_LVL = THR_I[W-1:0];

  logic signed [W-1:0] pm_n;
  logic                pm_en;
  logic                vld_n, dec_n, thr_n;

  // next-state logic
  always_comb begin
    if (load_init) begin
      pm_en = 1'b1;
      pm_n  = INIT_PM;
      vld_n = IS_START;
      dec_n = 1'b0;
      thr_n = 1'b0;
    end else begin
      pm_en = vld_d;                        // R5: gate nonsurvivors
      pm_n  = win;
      vld_n = vld_d;
      dec_n = dec_d;
      thr_n = vld_d && (win < THR_LVL);     // R6
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q  <= INIT_PM;
      vld_q <= IS_START;
      dec_q <= 1'b0;
      thr_q <= 1'b0;
    end else begin
      if (pm_en) begin
        pm_q <= pm_n;
      end
      vld_q <= vld_n;
      dec_q <= dec_n;
      thr_q <= thr_n;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_init && !vld_d) |=> $stable(pm_q));

  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> pm_q[W-1]);

  p_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q |-> (vld_q && (pm_q < THR_LVL)));

  p_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_init |=> ((vld_q == IS_START) && (pm_q == INIT_PM) && !thr_q && !dec_q));
endmodule

// File: rtl/surv_acs_cell.sv
module surv_acs_cell #(
  parameter int W        = 6,
  parameter int WIN      = 16,
  parameter int DELTA    = 2,
  parameter bit IS_START = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_init,
  input  logic signed [W-1:0] bm_up,
  input  logic signed [W-1:0] bm_lo,
  input  logic signed [W-1:0] pm_up,
  input  logic signed [W-1:0] pm_lo,
  input  logic                vld_up,
  input  logic                vld_lo,
  output logic signed [W-1:0] pm_out,
  output logic                vld_out,
  output logic                dec_out,
  output logic                thr_out
);
  localparam int NBR = 2;

  logic signed [W-1:0] bm_a  [NBR];
  logic signed [W-1:0] pm_a  [NBR];
  logic signed [W-1:0] sum_a [NBR];
  logic signed [W-1:0] win;
  logic                win_vld, win_dec;

  assign bm_a[0] = bm_up;
  assign bm_a[1] = bm_lo;
  assign pm_a[0] = pm_up;
  assign pm_a[1] = pm_lo;

  for (genvar g = 0; g < NBR; g++) begin : g_add
    acs_sat_add #(.W(W)) u_add (
      .a (pm_a[g]),
      .b (bm_a[g]),
      .s (sum_a[g])
    );
  end

  acs_pick #(.W(W)) u_pick (
    .sum_up (sum_a[0]),
    .sum_lo (sum_a[1]),
    .v_up   (vld_up),
    .v_lo   (vld_lo),
    .win    (win),
    .dec    (win_dec),
    .vld    (win_vld)
  );

  acs_state_reg #(
    .W(W), .WIN(WIN), .DELTA(DELTA), .IS_START(IS_START)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_init (load_init),
    .win       (win),
    .vld_d     (win_vld),
    .dec_d     (win_dec),
    .pm_q      (pm_out),
    .vld_q     (vld_out),
    .dec_q     (dec_out),
    .thr_q     (thr_out)
  );

  p_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_up && !vld_lo && !load_init) |=> (!vld_out && !dec_out));

  p_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld_up ^ vld_lo) && !load_init) |=> (dec_out == $past(vld_lo)));

  p_tie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_up && vld_lo && !load_init && (pm_up == pm_lo) && (bm_up == bm_lo))
      |=> !dec_out);

  p_sat_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_up && !vld_lo && !load_init && !pm_up[W-1] && !bm_up[W-1])
      |=> !vld_out);
endmodule

// File: tb/surv_acs_cell_bench.sv
module surv_acs_cell_bench;
  localparam int W     = 6;
  localparam int WIN   = 16;
  localparam int DELTA = 2;
  localparam int NS    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // ---------------- single cell under directed test ----------------
  logic                load_init = 1'b0;
  logic signed [W-1:0] bm_up = '0, bm_lo = '0, pm_up = '0, pm_lo = '0;
  logic                vld_up = 1'b0, vld_lo = 1'b0;
  logic signed [W-1:0] pm_out;
  logic                vld_out, dec_out, thr_out;

  surv_acs_cell #(.W(W), .WIN(WIN), .DELTA(DELTA), .IS_START(1'b1)) u_surv_acs_cell (
    .clk(clk), .rst_n(rst_n), .load_init(load_init),
    .bm_up(bm_up), .bm_lo(bm_lo), .pm_up(pm_up), .pm_lo(pm_lo),
    .vld_up(vld_up), .vld_lo(vld_lo),
    .pm_out(pm_out), .vld_out(vld_out), .dec_out(dec_out), .thr_out(thr_out)
  );

  // ---------------- four-state trellis of cells ----------------
  logic                tr_init = 1'b0;
  logic signed [W-1:0] tbm_up [NS];
  logic signed [W-1:0] tbm_lo [NS];
  logic signed [W-1:0] tpm    [NS];
  logic                tvld   [NS];
  logic                tdec   [NS];
  logic                tthr   [NS];

  for (genvar s = 0; s < NS; s++) begin : g_trel
    localparam int PU = (s << 1) % NS;
    localparam int PL = PU + 1;
    surv_acs_cell #(.W(W), .WIN(WIN), .DELTA(DELTA), .IS_START(s == 0)) u_cell (
      .clk(clk), .rst_n(rst_n), .load_init(tr_init),
      .bm_up(tbm_up[s]), .bm_lo(tbm_lo[s]), .pm_up(tpm[PU]), .pm_lo(tpm[PL]),
      .vld_up(tvld[PU]), .vld_lo(tvld[PL]),
      .pm_out(tpm[s]), .vld_out(tvld[s]), .dec_out(tdec[s]), .thr_out(tthr[s])
    );
  end

  // ---------------- helpers ----------------
  function automatic int sat(input int x);
    if (x > 31) return 31;
    if (x < -32) return -32;
    return x;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_cell(input string req, input int pm, input int v, input int d, input int t);
    chk(req, "pm_out",  int'(pm_out), pm);
    chk(req, "vld_out", int'(vld_out), v);
    chk(req, "dec_out", int'(dec_out), d);
    chk(req, "thr_out", int'(thr_out), t);
  endtask

  // drive at a falling edge, result visible after the next rising edge (R11)
  task automatic apply(input bit vu, input bit vl, input int pu, input int pl,
                       input int bu, input int bl);
    @(negedge clk);
    vld_up = vu; vld_lo = vl;
    pm_up = W'(pu); pm_lo = W'(pl); bm_up = W'(bu); bm_lo = W'(bl);
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk_cell("R7", -16, 1, 0, 0);
    chk("R7", "trellis state1 vld", int'(tvld[1]), 0);
    chk("R7", "trellis state1 pm", int'(tpm[1]), 0);
  endtask

  task automatic t_both_valid();
    apply(1, 1, -5, -10, 2, 1);   // -3 vs -9
    chk_cell("R1", -9, 1, 1, 0);
    apply(1, 1, -12, -1, 1, -3);  // -11 vs -4
    chk_cell("R1", -11, 1, 0, 0);
  endtask

  task automatic t_tie();
    apply(1, 1, -4, -6, 0, 2);    // -4 vs -4
    chk_cell("R9", -4, 1, 0, 0);
  endtask

  task automatic t_one_valid();
    apply(1, 0, -2, -30, 0, 0);   // lower would win but is invalid
    chk_cell("R2", -2, 1, 0, 0);
    apply(0, 1, -30, -3, -1, 0);  // upper would win but is invalid
    chk_cell("R2", -3, 1, 1, 0);
  endtask

  task automatic t_none_valid();
    apply(0, 0, -20, -20, -5, -5);
    chk_cell("R3", -3, 0, 0, 0);  // R5 hold of -3 as well
  endtask

  task automatic t_nonneg();
    apply(1, 0, -7, 0, 0, 0);
    chk_cell("R4", -7, 1, 0, 0);
    apply(1, 1, 2, 5, 1, -1);     // 3 vs 4: nonnegative winner
    chk_cell("R5", -7, 0, 0, 0);
  endtask

  task automatic t_threshold();
    apply(1, 0, -14, 0, 0, 0);    // at level: not below
    chk_cell("R6", -14, 1, 0, 0);
    apply(1, 0, -15, 0, 0, 0);    // one below level
    chk_cell("R6", -15, 1, 0, 1);
  endtask

  task automatic t_saturate();
    apply(1, 0, -30, 0, -10, 0);  // -40 clamps to -32
    chk_cell("R8", -32, 1, 0, 1);
    apply(0, 1, 0, -20, 0, -20);
    chk_cell("R8", -32, 1, 1, 1);
    apply(1, 0, 25, 0, 20, 0);    // 45 clamps to 31, no wrap to negative
    chk_cell("R8", -32, 0, 0, 0);
  endtask

  task automatic t_load_init();
    apply(1, 1, -30, -30, -2, -2);
    chk_cell("R11", -32, 1, 0, 1);
    @(negedge clk);
    load_init = 1'b1;
    vld_up = 1'b1; vld_lo = 1'b1; pm_up = -6'sd20; pm_lo = -6'sd25; bm_up = '0; bm_lo = '0;
    @(negedge clk);
    load_init = 1'b0;
    chk_cell("R10", -16, 1, 0, 0);
  endtask

  // trellis stepped against a bench model of R1..R6, R8, R9
  task automatic t_trellis();
    int em[NS], ev[NS], ed[NS], et[NS];
    int nm[NS], nv[NS], nd[NS], nt[NS];
    @(negedge clk);
    tr_init = 1'b1;
    @(negedge clk);
    tr_init = 1'b0;
    for (int s = 0; s < NS; s++) begin
      em[s] = (s == 0) ? -WIN : 0;
      ev[s] = (s == 0) ? 1 : 0;
      ed[s] = 0;
      et[s] = 0;
      chk("R10", "trellis init pm", int'(tpm[s]), em[s]);
      chk("R10", "trellis init vld", int'(tvld[s]), ev[s]);
    end
    for (int step = 0; step < 40; step++) begin
      for (int s = 0; s < NS; s++) begin
        int bu, bl, pu, pl, su, sl, w, d, any;
        bu = ((step * 7 + s * 3) % 9) - 6;
        bl = ((step * 5 + s * 3 + 4) % 9) - 6;
        if (step % 10 == 9) begin bu = 9; bl = 9; end
        tbm_up[s] = W'(bu);
        tbm_lo[s] = W'(bl);
        pu = (s << 1) % NS;
        pl = pu + 1;
        su = sat(em[pu] + bu);
        sl = sat(em[pl] + bl);
        any = ev[pu] | ev[pl];
        if (ev[pu] != 0 && ev[pl] != 0) begin
          if (sl < su) begin w = sl; d = 1; end else begin w = su; d = 0; end
        end else if (ev[pl] != 0) begin
          w = sl; d = 1;
        end else begin
          w = su; d = 0;
        end
        nv[s] = (any != 0 && w < 0) ? 1 : 0;
        nd[s] = (any != 0) ? d : 0;
        nm[s] = (nv[s] != 0) ? w : em[s];
        nt[s] = (nv[s] != 0 && w < DELTA - WIN) ? 1 : 0;
      end
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
        em[s] = nm[s]; ev[s] = nv[s]; ed[s] = nd[s]; et[s] = nt[s];
        chk("R1", "trellis pm", int'(tpm[s]), em[s]);
        chk("R4", "trellis vld", int'(tvld[s]), ev[s]);
        chk("R2", "trellis dec", int'(tdec[s]), ed[s]);
        chk("R6", "trellis thr", int'(tthr[s]), et[s]);
      end
    end
  endtask

  // ---------------- sequencing ----------------
  initial begin
    for (int s = 0; s < NS; s++) begin
      tbm_up[s] = '0;
      tbm_lo[s] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_both_valid();
    t_tie();
    t_one_valid();
    t_none_valid();
    t_nonneg();
    t_threshold();
    t_saturate();
    t_load_init();
    t_trellis();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule